// File: doc/BRIEF.md
# MAC Learning Forwarding Table

This block decides where a frame goes in a small Ethernet switch. It learns from the traffic it sees. Each learn request pairs a source MAC address with the port the frame arrived on. If the address is unknown, the block stores it. If the address is already stored, the block refreshes the entry and moves it to the latest port. Each lookup request gives a destination MAC and the ingress port. One clock later the block answers with a bitmask of egress ports.

The table is a small set of flip-flop entries, searched in parallel. Every entry carries its own countdown, so a silent station is dropped once its countdown runs out. When no entry is free, the entry with the least time left is replaced. Two masks can be written at any time while the block runs. The force-on mask adds ports to every answer and the force-off mask removes them. The ingress port is always removed last.

Each learn cycle resolves into one of four named actions, chosen by a `unique case`:
- `LRN_IDLE`: no request.
- `LRN_REFRESH`: the address is already stored.
- `LRN_FILL`: the address is new and an entry is free.
- `LRN_EVICT`: the address is new and no entry is free.

Each entry moves through two conditions:
- It becomes valid on a load.
- It becomes invalid when its countdown reaches zero.

The lookup path has two phases: request and registered answer.

Top module: `mac_fwd_table`

## Requirements
- R1: After reset, every entry is invalid and `result_valid` is low. A lookup made before any learn floods.
- R2: `result_valid` is high exactly one clock after a cycle with `lookup_valid` high. `result_mask` is zero whenever `result_valid` is low.
- R3: A learn of an address that is not stored writes the lowest-index invalid entry. A later lookup of that address returns only the learned port; bit i of every mask stands for port i. `result_hit` reports the hit.
- R4: A learn of an address that is already stored reloads that entry's countdown to `TIMEOUT` and replaces its port with the new source port. No second entry is created.
- R5: An entry loaded at clock edge E answers lookups sampled at edges E+1 through E+TIMEOUT. From edge E+TIMEOUT+1 on, lookups of that address flood.
- R6: A learn of a new address while all DEPTH entries are valid overwrites the entry with the smallest remaining count. A tie goes to the lowest index.
- R7: A lookup that misses floods to all ports. The destination FF:FF:FF:FF:FF:FF always floods, even if that address was learned.
- R8: The ingress port bit is always cleared in the answer, after the masks are applied.
- R9: The answer is ((base | `always_mask`) & ~`never_mask`) & ~ingress. Both masks are sampled in the request cycle and may change on any cycle.
- R10: When a learn hits an entry in the same cycle that its countdown would expire, the learn wins and the entry stays valid.
- R11: A lookup in the same cycle as a learn sees the table as it was before that learn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| learn_valid | input | 1 | Learn request strobe |
| learn_mac | input | 48 | Source MAC to learn |
| learn_port | input | $clog2(NUM_PORTS) | Port the source was seen on |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_mac | input | 48 | Destination MAC to resolve |
| lookup_port | input | $clog2(NUM_PORTS) | Ingress port of the frame |
| always_mask | input | NUM_PORTS | Ports forced on in every answer |
| never_mask | input | NUM_PORTS | Ports forced off in every answer |
| result_valid | output | 1 | Answer strobe, one clock after a request |
| result_mask | output | NUM_PORTS | Egress port bitmask |
| result_hit | output | 1 | Destination was found and is not broadcast |

## Verification
The bound checker verifies, on every cycle, the properties that can be read from one request and its answer. These are:
- the one-clock answer latency and the idle answer;
- that the ingress bit is always clear;
- that the force-off mask always wins and the force-on mask otherwise holds;
- that a broadcast always floods;
- that a hit names at most one port beyond the forced ones.

Table contents over time can only be shown by the bench scenarios, compared against a behavioural model of the table. These behaviours are:
- which entry a new address takes;
- choosing the eviction victim;
- refreshing and moving a port;
- the exact expiry cycle;
- the learn winning over expiry;
- a lookup in the same cycle as a learn seeing the old table.

// File: rtl/mac_fwd_pkg.sv
package mac_fwd_pkg;
    localparam int MAC_W = 48;
    typedef logic [MAC_W-1:0] mac_t;
    localparam mac_t MAC_BCAST = {MAC_W{1'b1}};

    typedef enum logic [1:0] {
        LRN_IDLE,
        LRN_REFRESH,
        LRN_FILL,
        LRN_EVICT
    } learn_act_e;
endpackage

// File: rtl/mac_fwd_entry.sv
module mac_fwd_entry
    import mac_fwd_pkg::*;
#(
    parameter int PW      = 3,
    parameter int AGE_W   = 16,
    parameter int TIMEOUT = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  mac_t             load_mac,
    input  logic [PW-1:0]    load_port,
    input  mac_t             learn_mac,
    input  mac_t             lookup_mac,
    output logic             valid_o,
    output logic [PW-1:0]    port_o,
    output logic [AGE_W-1:0] age_o,
    output logic             learn_hit_o,
    output logic             lookup_hit_o
);
    localparam logic [AGE_W-1:0] AGE_FULL = AGE_W'(TIMEOUT);

    logic             valid_q;
    mac_t             mac_q;
    logic [PW-1:0]    port_q;
    logic [AGE_W-1:0] age_q;

    // Load has priority over the countdown, so a refresh beats expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mac_q   <= '0;
            port_q  <= '0;
            age_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            mac_q   <= load_mac;
            port_q  <= load_port;
            age_q   <= AGE_FULL;
        end else if (valid_q) begin
            if (age_q <= AGE_W'(1)) begin
                valid_q <= 1'b0;
                age_q   <= '0;
            end else begin
                age_q <= age_q - AGE_W'(1);
            end
        end
    end

    always_comb begin
        valid_o      = valid_q;
        port_o       = port_q;
        age_o        = age_q;
        learn_hit_o  = valid_q && (mac_q == learn_mac);
        lookup_hit_o = valid_q && (mac_q == lookup_mac);
    end
endmodule

// File: rtl/mac_fwd_victim.sv
module mac_fwd_victim #(
    parameter int DEPTH = 8,
    parameter int AGE_W = 16,
    parameter int IW    = 3
) (
    input  logic [DEPTH-1:0]            valid_vec,
    input  logic [DEPTH-1:0][AGE_W-1:0] age_vec,
    output logic                        free_found,
    output logic [IW-1:0]               free_idx,
    output logic [IW-1:0]               oldest_idx
);
    logic [AGE_W-1:0] best_age;

    // Lowest-index free entry: scan downward so the last write wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    // Smallest remaining count; strict compare keeps the lowest index on ties.
    always_comb begin
        oldest_idx = '0;
        best_age   = age_vec[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (age_vec[i] < best_age) begin
                best_age   = age_vec[i];
                oldest_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mac_fwd_resolve.sv
module mac_fwd_resolve #(
    parameter int NUM_PORTS = 5,
    parameter int DEPTH     = 8,
    parameter int PW        = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [DEPTH-1:0]           hit_vec,
    input  logic [DEPTH-1:0][PW-1:0]   port_tab,
    input  logic                       bcast,
    input  logic [PW-1:0]              in_port,
    input  logic [NUM_PORTS-1:0]       always_mask,
    input  logic [NUM_PORTS-1:0]       never_mask,
    output logic                       result_valid,
    output logic [NUM_PORTS-1:0]       result_mask,
    output logic                       result_hit
);
    localparam logic [NUM_PORTS-1:0] ALL_PORTS = {NUM_PORTS{1'b1}};
    localparam logic [NUM_PORTS-1:0] ONE       = NUM_PORTS'(1);

    logic                 hit_any;
    logic [PW-1:0]        hit_port;
    logic [NUM_PORTS-1:0] base_mask;
    logic [NUM_PORTS-1:0] final_mask;

    always_comb begin
        hit_any  = |hit_vec;
        hit_port = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_port = hit_port | port_tab[i];
        end
        base_mask  = (hit_any && !bcast) ? (ONE << hit_port) : ALL_PORTS;
        final_mask = ((base_mask | always_mask) & ~never_mask) & ~(ONE << in_port);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            result_mask  <= '0;
            result_hit   <= 1'b0;
        end else begin
            result_valid <= req;
            result_mask  <= req ? final_mask : '0;
            result_hit   <= req && hit_any && !bcast;
        end
    end
endmodule

// File: rtl/mac_fwd_table.sv
module mac_fwd_table
    import mac_fwd_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int DEPTH     = 8,
    parameter int TIMEOUT   = 50000,
    localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int AGE_W    = $clog2(TIMEOUT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 learn_valid,
    input  logic [47:0]          learn_mac,
    input  logic [PW-1:0]        learn_port,
    input  logic                 lookup_valid,
    input  logic [47:0]          lookup_mac,
    input  logic [PW-1:0]        lookup_port,
    input  logic [NUM_PORTS-1:0] always_mask,
    input  logic [NUM_PORTS-1:0] never_mask,
    output logic                 result_valid,
    output logic [NUM_PORTS-1:0] result_mask,
    output logic                 result_hit
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]            valid_vec;
    logic [DEPTH-1:0][PW-1:0]    port_vec;
    logic [DEPTH-1:0][AGE_W-1:0] age_vec;
    logic [DEPTH-1:0]            learn_hit_vec;
    logic [DEPTH-1:0]            lookup_hit_vec;
    logic [DEPTH-1:0]            load_vec;

    logic          free_found;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] oldest_idx;
    logic [IW-1:0] refresh_idx;
    logic [IW-1:0] target_idx;
    learn_act_e    learn_act;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_entry
            mac_fwd_entry #(
                .PW(PW), .AGE_W(AGE_W), .TIMEOUT(TIMEOUT)
            ) u_entry (
                .clk          (clk),
                .rst_n        (rst_n),
                .load         (load_vec[g]),
                .load_mac     (learn_mac),
                .load_port    (learn_port),
                .learn_mac    (learn_mac),
                .lookup_mac   (lookup_mac),
                .valid_o      (valid_vec[g]),
                .port_o       (port_vec[g]),
                .age_o        (age_vec[g]),
                .learn_hit_o  (learn_hit_vec[g]),
                .lookup_hit_o (lookup_hit_vec[g])
            );
        end
    endgenerate

    mac_fwd_victim #(
        .DEPTH(DEPTH), .AGE_W(AGE_W), .IW(IW)
    ) u_victim (
        .valid_vec  (valid_vec),
        .age_vec    (age_vec),
        .free_found (free_found),
        .free_idx   (free_idx),
        .oldest_idx (oldest_idx)
    );

    // Addresses are unique in the table, so at most one hit bit is set.
    always_comb begin
        refresh_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (learn_hit_vec[i]) refresh_idx = refresh_idx | IW'(i);
        end
    end

    always_comb begin
        if (!learn_valid)        learn_act = LRN_IDLE;
        else if (|learn_hit_vec) learn_act = LRN_REFRESH;
        else if (free_found)     learn_act = LRN_FILL;
        else                     learn_act = LRN_EVICT;
    end

    always_comb begin
        target_idx = '0;
        load_vec   = '0;
        unique case (learn_act)
            LRN_IDLE:    target_idx = '0;
            LRN_REFRESH: target_idx = refresh_idx;
            LRN_FILL:    target_idx = free_idx;
            LRN_EVICT:   target_idx = oldest_idx;
        endcase
        if (learn_act != LRN_IDLE) load_vec[target_idx] = 1'b1;
    end

    mac_fwd_resolve #(
        .NUM_PORTS(NUM_PORTS), .DEPTH(DEPTH), .PW(PW)
    ) u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (lookup_valid),
        .hit_vec      (lookup_hit_vec),
        .port_tab     (port_vec),
        .bcast        (lookup_mac == MAC_BCAST),
        .in_port      (lookup_port),
        .always_mask  (always_mask),
        .never_mask   (never_mask),
        .result_valid (result_valid),
        .result_mask  (result_mask),
        .result_hit   (result_hit)
    );
endmodule

// File: rtl/mac_fwd_table_chk.sv
module mac_fwd_table_chk #(
    parameter int NUM_PORTS = 5,
    parameter int PW        = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lookup_valid,
    input logic [47:0]          lookup_mac,
    input logic [PW-1:0]        lookup_port,
    input logic [NUM_PORTS-1:0] always_mask,
    input logic [NUM_PORTS-1:0] never_mask,
    input logic                 result_valid,
    input logic [NUM_PORTS-1:0] result_mask,
    input logic                 result_hit
);
    localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);
    localparam logic [NUM_PORTS-1:0] ALL = {NUM_PORTS{1'b1}};

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> result_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> (!result_valid && result_mask == '0));

    p_no_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> ((result_mask & (ONE << $past(lookup_port))) == '0));

    p_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> ((result_mask & $past(never_mask)) == '0));

    p_always_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> ((($past(always_mask) & ~$past(never_mask)
                            & ~(ONE << $past(lookup_port))) & ~result_mask) == '0));

    p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_mac == 48'hFFFF_FFFF_FFFF) |=>
        (!result_hit && result_mask == (ALL & ~$past(never_mask) & ~(ONE << $past(lookup_port)))));

    p_hit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> (!result_hit || $countones(result_mask & ~$past(always_mask)) <= 1));
endmodule

bind mac_fwd_table mac_fwd_table_chk #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .lookup_mac   (lookup_mac),
    .lookup_port  (lookup_port),
    .always_mask  (always_mask),
    .never_mask   (never_mask),
    .result_valid (result_valid),
    .result_mask  (result_mask),
    .result_hit   (result_hit)
);

// File: tb/mac_fwd_table_bench.sv
module mac_fwd_table_bench;
    localparam int NP = 5;
    localparam int DP = 8;
    localparam int TO = 40;
    localparam int PW = 3;
    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          learn_valid = 1'b0;
    logic [47:0]   learn_mac = '0;
    logic [PW-1:0] learn_port = '0;
    logic          lookup_valid = 1'b0;
    logic [47:0]   lookup_mac = '0;
    logic [PW-1:0] lookup_port = '0;
    logic [NP-1:0] always_mask = '0;
    logic [NP-1:0] never_mask = '0;
    logic          result_valid;
    logic [NP-1:0] result_mask;
    logic          result_hit;

    always #10 clk = ~clk;

    mac_fwd_table #(.NUM_PORTS(NP), .DEPTH(DP), .TIMEOUT(TO)) u_mac_fwd_table (
        .clk(clk), .rst_n(rst_n),
        .learn_valid(learn_valid), .learn_mac(learn_mac), .learn_port(learn_port),
        .lookup_valid(lookup_valid), .lookup_mac(lookup_mac), .lookup_port(lookup_port),
        .always_mask(always_mask), .never_mask(never_mask),
        .result_valid(result_valid), .result_mask(result_mask), .result_hit(result_hit)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model of the table.
    bit          m_valid[DP];
    logic [47:0] m_mac[DP];
    int          m_port[DP];
    int          m_age[DP];
    bit          e_valid = 0;
    int          e_mask = 0;
    bit          e_hit = 0;
    string       e_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DP; i++) begin
                m_valid[i] = 0; m_age[i] = 0; m_port[i] = 0; m_mac[i] = '0;
            end
            e_valid = 0; e_mask = 0; e_hit = 0;
        end else begin
            int hit_i;
            int tgt;
            int base;
            e_tag   = cur_req;
            e_valid = lookup_valid;
            e_mask  = 0;
            e_hit   = 0;
            if (lookup_valid) begin
                hit_i = -1;
                for (int i = 0; i < DP; i++)
                    if (m_valid[i] && m_mac[i] == lookup_mac) hit_i = i;
                if (hit_i >= 0 && lookup_mac != BC) begin
                    base = 1 << m_port[hit_i];
                    e_hit = 1;
                end else begin
                    base = (1 << NP) - 1;
                end
                e_mask = ((base | int'(always_mask)) & ~int'(never_mask))
                         & ~(1 << int'(lookup_port)) & ((1 << NP) - 1);
            end
            tgt = -1;
            if (learn_valid) begin
                for (int i = 0; i < DP; i++)
                    if (m_valid[i] && m_mac[i] == learn_mac) tgt = i;
                if (tgt < 0)
                    for (int i = DP - 1; i >= 0; i--)
                        if (!m_valid[i]) tgt = i;
                if (tgt < 0) begin
                    tgt = 0;
                    for (int i = 1; i < DP; i++)
                        if (m_age[i] < m_age[tgt]) tgt = i;
                end
            end
            for (int i = 0; i < DP; i++) begin
                if (i == tgt) begin
                    m_valid[i] = 1; m_age[i] = TO;
                    m_mac[i] = learn_mac; m_port[i] = int'(learn_port);
                end else if (m_valid[i]) begin
                    if (m_age[i] <= 1) begin m_valid[i] = 0; m_age[i] = 0; end
                    else m_age[i] = m_age[i] - 1;
                end
            end
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(result_valid == e_valid, e_tag, "result_valid", int'(result_valid), int'(e_valid));
            check(int'(result_mask) == e_mask, e_tag, "result_mask", int'(result_mask), e_mask);
            check(result_hit == e_hit, e_tag, "result_hit", int'(result_hit), int'(e_hit));
        end
    end

    task automatic cyc(bit lv, logic [47:0] lm, int lp, bit qv, logic [47:0] qm, int qp);
        @(negedge clk);
        learn_valid  = lv; learn_mac  = lm; learn_port  = PW'(lp);
        lookup_valid = qv; lookup_mac = qm; lookup_port = PW'(qp);
    endtask

    task automatic look(logic [47:0] qm, int qp);
        cyc(0, '0, 0, 1, qm, qp);
    endtask

    task automatic learn(logic [47:0] lm, int lp);
        cyc(1, lm, lp, 0, '0, 0);
    endtask

    function automatic logic [47:0] mk(int n);
        return {40'h02_00_00_00_00, 8'(n)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(result_valid == 0, "R1", "result_valid in reset", int'(result_valid), 0);
        check(result_mask == 0, "R1", "result_mask in reset", int'(result_mask), 0);
        @(negedge clk); rst_n = 1;
        cur_req = "R1"; look(mk(1), 0);
        cur_req = "R2"; cyc(0, '0, 0, 0, '0, 0); look(mk(1), 2);
        cur_req = "R3"; learn(mk(1), 1); look(mk(1), 0); look(mk(1), 4);
        cur_req = "R8"; look(mk(1), 1); look(mk(9), 3);
        cur_req = "R4"; learn(mk(1), 3); look(mk(1), 0); look(mk(1), 3);
        cur_req = "R7"; learn(BC, 2); look(BC, 0); look(mk(77), 4);
        cur_req = "R9";
        always_mask = 5'b10000; never_mask = 5'b00010;
        look(mk(1), 0); look(mk(55), 2);
        always_mask = 5'b00011; never_mask = 5'b01000;
        look(mk(1), 4); look(BC, 1);
        always_mask = '0; never_mask = '0;
        cur_req = "R11"; cyc(1, mk(2), 4, 1, mk(2), 0); look(mk(2), 0);
        cur_req = "R5"; learn(mk(3), 2);
        for (int i = 0; i < TO + 4; i++) look(mk(3), 0);
        cur_req = "R10"; learn(mk(4), 1);
        for (int i = 0; i < TO - 1; i++) look(mk(4), 0);
        learn(mk(4), 2);
        for (int i = 0; i < 4; i++) look(mk(4), 0);
        cur_req = "R6";
        for (int i = 0; i < TO + 3; i++) cyc(0, '0, 0, 0, '0, 0);
        for (int i = 0; i < DP; i++) learn(mk(16 + i), i % NP);
        learn(mk(40), 4);
        for (int i = 0; i < DP; i++) look(mk(16 + i), 4);
        look(mk(40), 0);
        learn(mk(17), 0); learn(mk(41), 3);
        for (int i = 0; i < DP; i++) look(mk(16 + i), 3);
        cur_req = "R3";
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            logic [47:0] lm = mk(r % 14);
            logic [47:0] qm = ((r >> 8) % 16 == 0) ? BC : mk((r >> 4) % 14);
            if ((r >> 12) % 97 == 0) begin
                always_mask = NP'(r >> 16); never_mask = NP'(r >> 21);
            end
            cyc((r >> 26) % 3 == 0, lm, (r >> 13) % NP, (r >> 28) % 2 == 0, qm, (r >> 5) % NP);
        end
        cyc(0, '0, 0, 0, '0, 0);
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule